// File: doc/BRIEF.md
# Masked Parallel Scan Chains with Parity Compaction

This block wraps a wide internal state register as a set of parallel scan chains of equal length. A test-control input picks the cell source: in normal operation every cell can load functional capture data in a single clock, and in test operation the cells of each chain form a shift register fed from that chain's own scan-in pin. On every shift cycle, the bit leaving the end of each chain is ANDed with that chain's mask bit. The masked bits are XORed together into one registered observable bit.

The mask comes from a generator seeded by test-supplied data. In static operation the mask stays fixed from one seed load to the next. In dynamic operation it is stepped once per shift cycle by a maximal-length LFSR, so the same seed always reproduces the same mask sequence.

Two optional protections are selected by inputs. The first forces the primary inputs to zero while test operation is active. The second folds the primary-input value into the mask seed, so that different functional inputs yield different masks.

Top module: `scan_mask_compactor`

## Requirements
- R1: With test_mode=0 and capture=1, all N×L cells load func_d in one clock; cell j of chain c is state bit c*L+j.
- R2: With test_mode=1 and shift_en=1, cell 0 of chain c loads scan_in[c], and cell j loads cell j-1 of the same chain.
- R3: capture has no effect while test_mode=1, and the cells hold when neither a capture nor a shift takes place.
- R4: On each shift clock, compact_out is updated to the XOR over all chains c of (cell L-1 of chain c AND mask bit c). The cell values used are those from before that shift.
- R5: The mask is bit c of the generator state for chain c. In static mode (dyn_mode=0) the mask changes only on seed_load, and a chain whose mask bit is 0 contributes nothing for the whole session.
- R6: seed_load=1 loads the generator state from the effective seed. In dynamic mode (dyn_mode=1) the state advances once after each shift: the state shifts left by one and the feedback bit, the XOR of state bits 15, 13, 12 and 10, enters at bit 0.
- R7: Reloading the same seed and applying the same capture data and shift sequence reproduces the identical compact_out stream in dynamic mode.
- R8: pi_out equals pi except when gate_pi=1 and test_mode=1, in which case pi_out is all zeros.
- R9: With mix_pi=1, the effective seed is seed XOR the fold of pi, where bit i of pi is XORed into fold bit i mod SEED_W. With mix_pi=0 it is seed alone. An all-zero effective seed is replaced by 1.
- R10: Synchronous active-high rst clears all cells, the generator state and compact_out.
- R11: compact_out holds its value on every clock without a shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | 0 = functional capture, 1 = scan shift |
| capture | input | 1 | Load func_d into all cells (normal mode) |
| shift_en | input | 1 | Shift all chains one place (test mode) |
| dyn_mode | input | 1 | 0 = static mask, 1 = mask stepped per shift |
| gate_pi | input | 1 | Force pi_out to zero in test mode |
| mix_pi | input | 1 | Fold pi into the mask seed |
| seed_load | input | 1 | Load mask generator from effective seed |
| seed | input | SEED_W | Test-supplied mask seed |
| pi | input | PI_W | Primary inputs |
| func_d | input | N_CHAINS*CHAIN_LEN | Functional capture data |
| scan_in | input | N_CHAINS | Per-chain serial inputs |
| pi_out | output | PI_W | Primary inputs after optional gating |
| state_q | output | N_CHAINS*CHAIN_LEN | Current cell values |
| compact_out | output | 1 | Registered masked parity |

## Verification
The case hardest to reach from the ports is a dynamic-mask stream that must match bit for bit across two separate sessions. The bench reproduces the full sequence of seed load, capture and unload twice and compares the two recorded streams. A one-hot static seed isolates a single chain, so the parity reveals exactly that chain's tail bits. A seed whose mask byte is zero shows that blocked chains stay silent. For seed mixing, the seed is chosen equal to the fold of pi, so that the all-zero substitution is exercised.

// File: rtl/scmc_pkg.sv
package scmc_pkg;
    localparam int DEF_N_CHAINS  = 8;
    localparam int DEF_CHAIN_LEN = 8;
    localparam int DEF_PI_W      = 32;
    localparam int DEF_SEED_W    = 16;
    // feedback taps 15,13,12,10: maximal length for 16 bits
    localparam logic [DEF_SEED_W-1:0] DEF_TAPS = 16'hB400;
endpackage

// File: rtl/scan_cell_array.sv
module scan_cell_array #(
    parameter int N = 8,
    parameter int L = 8,
    localparam int W = N * L
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         test_mode,
    input  logic         capture,
    input  logic         shift_en,
    input  logic [W-1:0] func_d,
    input  logic [N-1:0] scan_in,
    output logic [W-1:0] state_q,
    output logic [N-1:0] tail
);
    typedef struct packed {
        logic [W-1:0] cells;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (test_mode && shift_en) begin
            for (int c = 0; c < N; c++) begin
                for (int j = L - 1; j > 0; j--) begin
                    st_d.cells[c*L+j] = st_q.cells[c*L+j-1];
                end
                st_d.cells[c*L] = scan_in[c];
            end
        end else if (!test_mode && capture) begin
            st_d.cells = func_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign state_q = st_q.cells;

    generate
        for (genvar g = 0; g < N; g++) begin : g_tail
            assign tail[g] = st_q.cells[g*L+L-1];

            // R2: head cell takes the chain's serial input on a shift
            a_r2_head_loads: assert property (@(posedge clk) disable iff (rst)
                (test_mode && shift_en) |=> (st_q.cells[g*L] == $past(scan_in[g])));
        end
    endgenerate

    // R1: normal-mode capture loads functional data
    a_r1_capture: assert property (@(posedge clk) disable iff (rst)
        (!test_mode && capture) |=> (state_q == $past(func_d)));

    // R3: capture ignored in test mode when not shifting
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (test_mode && !shift_en) |=> $stable(state_q));
endmodule

// File: rtl/mask_gen.sv
module mask_gen #(
    parameter int N      = 8,
    parameter int PI_W   = 32,
    parameter int SEED_W = 16,
    parameter logic [SEED_W-1:0] TAPS = 16'hB400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_load,
    input  logic [SEED_W-1:0] seed,
    input  logic              mix_pi,
    input  logic [PI_W-1:0]   pi,
    input  logic              advance,
    output logic [N-1:0]      mask
);
    typedef struct packed {
        logic [SEED_W-1:0] lfsr;
    } st_t;

    st_t st_d, st_q;
    logic [SEED_W-1:0] pi_fold;
    logic [SEED_W-1:0] seed_mix;
    logic              fb;

    always_comb begin
        pi_fold = '0;
        for (int i = 0; i < PI_W; i++) begin
            pi_fold[i % SEED_W] = pi_fold[i % SEED_W] ^ pi[i];
        end
        seed_mix = mix_pi ? (seed ^ pi_fold) : seed;
        if (seed_mix == '0) seed_mix = {{(SEED_W-1){1'b0}}, 1'b1};
    end

    assign fb = ^(st_q.lfsr & TAPS);

    always_comb begin
        st_d = st_q;
        if (seed_load)    st_d.lfsr = seed_mix;
        else if (advance) st_d.lfsr = {st_q.lfsr[SEED_W-2:0], fb};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign mask = st_q.lfsr[N-1:0];

    // R5: without a load or a step the mask never moves
    a_r5_mask_static: assert property (@(posedge clk) disable iff (rst)
        (!seed_load && !advance) |=> $stable(mask));

    // R9: a loaded generator state is never all zero
    a_r9_nonzero_load: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> (st_q.lfsr != '0));
endmodule

// File: rtl/xor_compactor.sv
module xor_compactor #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift,
    input  logic [N-1:0] tail,
    input  logic [N-1:0] mask,
    output logic         comp_q
);
    typedef struct packed {
        logic bit_v;
    } st_t;

    st_t st_d, st_q;
    logic [N-1:0] gated;

    assign gated = tail & mask;

    always_comb begin
        st_d = st_q;
        if (shift) st_d.bit_v = ^gated;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign comp_q = st_q.bit_v;

    // R11: the observed bit only moves on a shift clock
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !shift |=> $stable(comp_q));

    // R4: with every chain blocked the shifted-out bit is zero
    a_r4_blocked_zero: assert property (@(posedge clk) disable iff (rst)
        (shift && mask == '0) |=> !comp_q);
endmodule

// File: rtl/pi_guard.sv
module pi_guard #(
    parameter int PI_W = 32
) (
    input  logic            test_mode,
    input  logic            gate_pi,
    input  logic [PI_W-1:0] pi,
    output logic [PI_W-1:0] pi_out
);
    logic pass_n;

    always_comb begin
        pass_n = gate_pi & test_mode;
        pi_out = pi & {PI_W{~pass_n}};
    end
endmodule

// File: rtl/scan_mask_compactor.sv
module scan_mask_compactor #(
    parameter int N_CHAINS  = scmc_pkg::DEF_N_CHAINS,
    parameter int CHAIN_LEN = scmc_pkg::DEF_CHAIN_LEN,
    parameter int PI_W      = scmc_pkg::DEF_PI_W,
    parameter int SEED_W    = scmc_pkg::DEF_SEED_W,
    parameter logic [SEED_W-1:0] TAPS = scmc_pkg::DEF_TAPS,
    localparam int W = N_CHAINS * CHAIN_LEN
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                test_mode,
    input  logic                capture,
    input  logic                shift_en,
    input  logic                dyn_mode,
    input  logic                gate_pi,
    input  logic                mix_pi,
    input  logic                seed_load,
    input  logic [SEED_W-1:0]   seed,
    input  logic [PI_W-1:0]     pi,
    input  logic [W-1:0]        func_d,
    input  logic [N_CHAINS-1:0] scan_in,
    output logic [PI_W-1:0]     pi_out,
    output logic [W-1:0]        state_q,
    output logic                compact_out
);
    logic                shift;
    logic [N_CHAINS-1:0] tail;
    logic [N_CHAINS-1:0] mask;

    assign shift = test_mode & shift_en;

    scan_cell_array #(.N(N_CHAINS), .L(CHAIN_LEN)) u_cells (
        .clk(clk), .rst(rst), .test_mode(test_mode), .capture(capture),
        .shift_en(shift_en), .func_d(func_d), .scan_in(scan_in),
        .state_q(state_q), .tail(tail)
    );

    mask_gen #(.N(N_CHAINS), .PI_W(PI_W), .SEED_W(SEED_W), .TAPS(TAPS)) u_mask (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed(seed),
        .mix_pi(mix_pi), .pi(pi), .advance(shift & dyn_mode), .mask(mask)
    );

    xor_compactor #(.N(N_CHAINS)) u_comp (
        .clk(clk), .rst(rst), .shift(shift), .tail(tail), .mask(mask),
        .comp_q(compact_out)
    );

    pi_guard #(.PI_W(PI_W)) u_guard (
        .test_mode(test_mode), .gate_pi(gate_pi), .pi(pi), .pi_out(pi_out)
    );

    // R8: gated primary inputs read as zero in test mode
    a_r8_pi_blocked: assert property (@(posedge clk) disable iff (rst)
        (gate_pi && test_mode) |-> (pi_out == '0));

    // R10: reset leaves every cell and the observed bit cleared
    a_r10_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_q == '0 && !compact_out));
endmodule

// File: tb/sim_scan_mask_compactor.sv
`timescale 1ns/1ps
module sim_scan_mask_compactor;
    localparam int N = 8;
    localparam int L = 8;
    localparam int W = N * L;
    localparam int PW = 32;
    localparam int SW = 16;

    logic clk = 1'b0;
    logic rst, test_mode, capture, shift_en, dyn_mode, gate_pi, mix_pi, seed_load;
    logic [SW-1:0] seed;
    logic [PW-1:0] pi;
    logic [W-1:0]  func_d;
    logic [N-1:0]  scan_in;
    logic [PW-1:0] pi_out;
    logic [W-1:0]  state_q;
    logic          compact_out;

    int n_chk = 0;
    int n_bad = 0;

    logic [W-1:0]  m_state;
    logic [SW-1:0] m_gen;

    always #2.5 clk = ~clk;

    scan_mask_compactor u0 (
        .clk(clk), .rst(rst), .test_mode(test_mode), .capture(capture),
        .shift_en(shift_en), .dyn_mode(dyn_mode), .gate_pi(gate_pi),
        .mix_pi(mix_pi), .seed_load(seed_load), .seed(seed), .pi(pi),
        .func_d(func_d), .scan_in(scan_in), .pi_out(pi_out),
        .state_q(state_q), .compact_out(compact_out)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] gen_next(input logic [SW-1:0] s);
        return {s[SW-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [SW-1:0] eff_seed(input logic [SW-1:0] s, input logic [PW-1:0] p,
                                               input logic mx);
        logic [SW-1:0] r = s;
        if (mx) for (int i = 0; i < PW; i++) r[i % SW] ^= p[i];
        if (r == '0) r = 1;
        return r;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1; test_mode = 0; capture = 0; shift_en = 0; dyn_mode = 0;
        gate_pi = 0; mix_pi = 0; seed_load = 0; seed = 0; pi = 0; func_d = 0; scan_in = 0;
        step(); step();
        rst = 0;
        m_state = '0; m_gen = '0;
    endtask

    task automatic load_seed(input logic [SW-1:0] s);
        seed = s; seed_load = 1;
        step();
        seed_load = 0;
        m_gen = eff_seed(s, pi, mix_pi);
    endtask

    task automatic do_capture(input logic [W-1:0] d);
        test_mode = 0; capture = 1; func_d = d;
        step();
        capture = 0;
        m_state = d;
    endtask

    task automatic model_shift(input logic [N-1:0] sin);
        for (int c = 0; c < N; c++) begin
            for (int j = L - 1; j > 0; j--) m_state[c*L+j] = m_state[c*L+j-1];
            m_state[c*L] = sin[c];
        end
    endtask

    task automatic unload(input string tag, output logic [L-1:0] stream);
        logic e;
        logic [N-1:0] tl;
        test_mode = 1; shift_en = 1; scan_in = '0;
        for (int k = 0; k < L; k++) begin
            for (int c = 0; c < N; c++) tl[c] = m_state[c*L+L-1];
            e = ^(tl & m_gen[N-1:0]);
            step();
            check(tag, {63'b0, compact_out}, {63'b0, e});
            stream[k] = compact_out;
            if (dyn_mode) m_gen = gen_next(m_gen);
            model_shift('0);
        end
        shift_en = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R10 state", state_q, '0);
        check("R10 compact", {63'b0, compact_out}, '0);
    endtask

    task automatic t_capture();
        do_capture(64'hDEAD_BEEF_0123_4567);
        check("R1 capture", state_q, 64'hDEAD_BEEF_0123_4567);
        test_mode = 1; capture = 1; func_d = 64'h1111_2222_3333_4444;
        step();
        capture = 0;
        check("R3 capture ignored", state_q, 64'hDEAD_BEEF_0123_4567);
        step();
        check("R3 hold", state_q, 64'hDEAD_BEEF_0123_4567);
    endtask

    task automatic t_shift_in();
        logic [N-1:0] pat;
        test_mode = 1; shift_en = 1;
        for (int k = 0; k < L; k++) begin
            pat = 8'hA5 ^ 8'(k * 8'h13);
            scan_in = pat;
            step();
            model_shift(pat);
        end
        shift_en = 0;
        check("R2 shift in", state_q, m_state);
    endtask

    task automatic t_static();
        logic [L-1:0] s;
        logic [L-1:0] exp0;
        do_reset();
        dyn_mode = 0;
        load_seed(16'h0001);
        do_capture(64'h0123_4567_89AB_CDEF);
        for (int k = 0; k < L; k++) exp0[k] = m_state[L-1-k];
        unload("R4 single chain", s);
        check("R5 chain0 only", {56'b0, s}, {56'b0, exp0});
        load_seed(16'h0100);
        do_capture(64'hFFFF_FFFF_FFFF_FFFF);
        unload("R5 all blocked", s);
        check("R5 blocked stream", {56'b0, s}, '0);
        load_seed(16'h3C5A);
        do_capture(64'h5A5A_0F0F_C3C3_9696);
        unload("R4 static parity", s);
        step();
        check("R11 compact holds", {63'b0, compact_out}, {63'b0, s[L-1]});
    endtask

    task automatic t_dynamic();
        logic [L-1:0] s1, s2;
        do_reset();
        dyn_mode = 1;
        load_seed(16'hACE1);
        do_capture(64'h9E37_79B9_7F4A_7C15);
        unload("R6 dynamic", s1);
        load_seed(16'hACE1);
        do_capture(64'h9E37_79B9_7F4A_7C15);
        unload("R6 dynamic repeat", s2);
        check("R7 reproduce", {56'b0, s2}, {56'b0, s1});
    endtask

    task automatic t_pi_gate();
        logic [L-1:0] s;
        pi = 32'hCAFE_F00D; gate_pi = 0; test_mode = 1;
        step();
        check("R8 ungated test", {32'b0, pi_out}, {32'b0, pi});
        gate_pi = 1; test_mode = 0;
        step();
        check("R8 gated normal", {32'b0, pi_out}, {32'b0, pi});
        test_mode = 1;
        step();
        check("R8 gated test", {32'b0, pi_out}, '0);
        gate_pi = 0;
        s = '0;
        if (s != '0) $display("unused");
    endtask

    task automatic t_mix();
        logic [L-1:0] s;
        logic [SW-1:0] f;
        do_reset();
        dyn_mode = 1; mix_pi = 1; pi = 32'h1357_9BDF;
        load_seed(16'h4242);
        do_capture(64'h0F1E_2D3C_4B5A_6978);
        unload("R9 mixed seed", s);
        f = 16'h1357 ^ 16'h9BDF;
        dyn_mode = 0;
        load_seed(f);
        do_capture(64'h0000_0000_0000_0080);
        unload("R9 zero substitute", s);
        check("R9 zero->1 stream", {56'b0, s}, {56'b0, 8'h01});
        mix_pi = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_capture();
        t_shift_in();
        t_static();
        t_dynamic();
        t_pi_gate();
        t_mix();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule